// File: doc/BRIEF.md
# CPU Bus Address Decoder

This block sits on the address/data bus of an 8-bit processor that has a 16-bit address space. It owns a small work RAM. Every bus cycle it classifies the address into one of four areas: work RAM, a bank of video-controller registers, a small I/O window that holds a sprite-DMA trigger, and a cartridge port. It then raises the matching strobe, or loads the RAM. It adds no wait states and does no arbitration. Each cycle in which `bus_valid` is high counts as one complete access.

Decoding is partial. The 2 KB RAM repeats four times below 0x2000. The eight video registers repeat every 8 bytes from 0x2000 to 0x3FFF. Each video register has its own read permission, and a read that is not permitted does not halt anything. It returns 0x00 and raises a one-cycle error flag. Read data is always returned one cycle after the read is issued. The byte comes from whichever source was selected in the issuing cycle.

Top module: `cbd_bus_decoder`

## Requirements
- R1: A bus access with address below 0x2000 reaches the internal RAM at index `bus_addr[10:0]`, so the four 2 KB copies alias. A read returns the stored byte on `bus_rdata` in the cycle after it is issued.
- R2: An access with address from 0x2000 to 0x3FFF drives `vid_idx` = `bus_addr[2:0]`. A write there pulses `vid_wr_stb` in the same cycle for any index 0 to 7, with `vid_wdata` = `bus_wdata`.
- R3: A read of video index 2, 4 or 7 pulses `vid_rd_stb` in the issuing cycle. The next cycle it returns `vid_rdata` on `bus_rdata`, with `bus_err` low.
- R4: A read of video index 0, 1, 3, 5 or 6 raises no `vid_rd_stb`. In the next cycle it returns `bus_rdata` = 0x00 with `bus_err` high.
- R5: A write to 0x4014 pulses `dma_start` in the same cycle, with `dma_page` = `bus_wdata`. A read of 0x4014 raises no `dma_start`.
- R6: A read from 0x4000 to 0x401F returns 0x00 in the next cycle. A write in that range other than to 0x4014 raises no strobe.
- R7: An access at 0x4020 or above pulses `cart_rd_stb` or `cart_wr_stb`, with `cart_addr` = `bus_addr` and `cart_wdata` = `bus_wdata`. A read returns `cart_rdata` on `bus_rdata` in the next cycle.
- R8: No strobe is raised while `bus_valid` is low, and at most one strobe is high in any cycle. The cycle after a cycle with no read returns `bus_rdata` = 0x00.
- R9: After reset, `bus_rdata` is 0x00 and `bus_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read |
| bus_err | output | 1 | Forbidden video-register read, one cycle after the read |
| vid_rd_stb | output | 1 | Video register read pulse |
| vid_wr_stb | output | 1 | Video register write pulse |
| vid_idx | output | 3 | Video register index |
| vid_wdata | output | 8 | Video register write data |
| vid_rdata | input | 8 | Video register read data, valid the cycle after `vid_rd_stb` |
| dma_start | output | 1 | Sprite-DMA start pulse |
| dma_page | output | 8 | DMA source page |
| cart_rd_stb | output | 1 | Cartridge read pulse |
| cart_wr_stb | output | 1 | Cartridge write pulse |
| cart_addr | output | 16 | Cartridge address |
| cart_wdata | output | 8 | Cartridge write data |
| cart_rdata | input | 8 | Cartridge read data, valid the cycle after `cart_rd_stb` |

## Verification
The bench goes after the area edges: 0x1FFF against 0x2000, 0x3FFF against 0x4000, and 0x401F against 0x4020. A decoder with an off-by-one compare would send these to the wrong device, or return a cartridge byte where zero is due. It reads RAM back through all four mirrors and writes through the top mirror. Dropping an address bit, or masking with the wrong width, shows up as stale or foreign bytes. Every video index is read. A wrong permission mask either strobes a write-only register or flags a legal read. The bench checks that 0x4014 fires DMA only on a write. It checks that nothing fires while `bus_valid` is low. A mux that picked its source from the current cycle instead of the issuing cycle would hand back the wrong device's byte on reads issued back to back.

// File: rtl/cbd_pkg.sv
`timescale 1ns/1ps
package cbd_pkg;
   typedef enum logic [1:0] {
      AREA_RAM  = 2'd0,
      AREA_VID  = 2'd1,
      AREA_IO   = 2'd2,
      AREA_CART = 2'd3
   } area_e;

   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,
      SRC_RAM  = 2'd1,
      SRC_VID  = 2'd2,
      SRC_CART = 2'd3
   } rsrc_e;
endpackage

// File: rtl/cbd_area_decode.sv
`timescale 1ns/1ps
module cbd_area_decode
   import cbd_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] VID_BASE  = 'h2000,
   parameter logic [ADDR_W-1:0] IO_BASE   = 'h4000,
   parameter logic [ADDR_W-1:0] CART_BASE = 'h4020
) (
   input  logic [ADDR_W-1:0] addr,
   output area_e             area
);
   always_comb begin
      if (addr < VID_BASE)       area = AREA_RAM;
      else if (addr < IO_BASE)   area = AREA_VID;
      else if (addr < CART_BASE) area = AREA_IO;
      else                       area = AREA_CART;
   end
endmodule

// File: rtl/cbd_work_ram.sv
`timescale 1ns/1ps
module cbd_work_ram #(
   parameter int DEPTH  = 2048,
   parameter int DATA_W = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [AW-1:0]     idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
      if (re) rdata    <= mem[idx];
   end
endmodule

// File: rtl/cbd_read_mux.sv
`timescale 1ns/1ps
module cbd_read_mux
   import cbd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rsrc_e             src_d,
   input  logic              err_d,
   input  logic [DATA_W-1:0] ram_q,
   input  logic [DATA_W-1:0] vid_q,
   input  logic [DATA_W-1:0] cart_q,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);
   rsrc_e src_q;
   logic  err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= SRC_ZERO;
         err_q <= 1'b0;
      end else begin
         src_q <= src_d;
         err_q <= err_d;
      end
   end

   always_comb begin
      unique case (src_q)
         SRC_RAM:  rdata = ram_q;
         SRC_VID:  rdata = vid_q;
         SRC_CART: rdata = cart_q;
         default:  rdata = '0;
      endcase
   end

   assign err = err_q;
endmodule

// File: rtl/cbd_bus_decoder.sv
`timescale 1ns/1ps
module cbd_bus_decoder
   import cbd_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int RAM_BYTES = 2048,
   parameter int NUM_VID   = 8,
   parameter logic [ADDR_W-1:0]  VID_BASE    = 'h2000,
   parameter logic [ADDR_W-1:0]  IO_BASE     = 'h4000,
   parameter logic [ADDR_W-1:0]  CART_BASE   = 'h4020,
   parameter logic [ADDR_W-1:0]  DMA_ADDR    = 'h4014,
   parameter logic [NUM_VID-1:0] VID_RD_MASK = 8'b1001_0100,
   parameter logic [NUM_VID-1:0] VID_WR_MASK = 8'b1111_1111,
   localparam int RAM_AW = $clog2(RAM_BYTES),
   localparam int VID_IW = $clog2(NUM_VID)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   output logic              vid_rd_stb,
   output logic              vid_wr_stb,
   output logic [VID_IW-1:0] vid_idx,
   output logic [DATA_W-1:0] vid_wdata,
   input  logic [DATA_W-1:0] vid_rdata,
   output logic              dma_start,
   output logic [DATA_W-1:0] dma_page,
   output logic              cart_rd_stb,
   output logic              cart_wr_stb,
   output logic [ADDR_W-1:0] cart_addr,
   output logic [DATA_W-1:0] cart_wdata,
   input  logic [DATA_W-1:0] cart_rdata
);
   // elaboration-time parameter checks
   generate
      if ((RAM_BYTES & (RAM_BYTES - 1)) != 0)
         $error("RAM_BYTES must be a power of two");
      if ((NUM_VID & (NUM_VID - 1)) != 0)
         $error("NUM_VID must be a power of two");
      if (RAM_BYTES > int'(VID_BASE))
         $error("RAM larger than its address area");
      if (!(VID_BASE < IO_BASE && IO_BASE < CART_BASE))
         $error("area bases must ascend");
      if (!(DMA_ADDR >= IO_BASE && DMA_ADDR < CART_BASE))
         $error("DMA address must sit in the I/O window");
   endgenerate

   area_e             area;
   logic              acc_rd, acc_wr;
   logic              in_ram, in_vid, in_io, in_cart;
   logic              vid_can_rd, vid_can_wr;
   logic [DATA_W-1:0] ram_q;
   rsrc_e             src_d;
   logic              err_d;

   cbd_area_decode #(
      .ADDR_W(ADDR_W), .VID_BASE(VID_BASE),
      .IO_BASE(IO_BASE), .CART_BASE(CART_BASE)
   ) i_decode (
      .addr(bus_addr),
      .area(area)
   );

   assign acc_rd  = bus_valid && !bus_we;
   assign acc_wr  = bus_valid &&  bus_we;
   assign in_ram  = (area == AREA_RAM);
   assign in_vid  = (area == AREA_VID);
   assign in_io   = (area == AREA_IO);
   assign in_cart = (area == AREA_CART);

   assign vid_idx    = bus_addr[VID_IW-1:0];
   assign vid_can_rd = VID_RD_MASK[vid_idx];
   assign vid_can_wr = VID_WR_MASK[vid_idx];

   cbd_work_ram #(
      .DEPTH(RAM_BYTES), .DATA_W(DATA_W)
   ) i_ram (
      .clk  (clk),
      .we   (acc_wr && in_ram),
      .re   (acc_rd && in_ram),
      .idx  (bus_addr[RAM_AW-1:0]),
      .wdata(bus_wdata),
      .rdata(ram_q)
   );

   // strobes
   assign vid_rd_stb  = acc_rd && in_vid && vid_can_rd;
   assign vid_wr_stb  = acc_wr && in_vid && vid_can_wr;
   assign vid_wdata   = bus_wdata;
   assign dma_start   = acc_wr && in_io && (bus_addr == DMA_ADDR);
   assign dma_page    = bus_wdata;
   assign cart_rd_stb = acc_rd && in_cart;
   assign cart_wr_stb = acc_wr && in_cart;
   assign cart_addr   = bus_addr;
   assign cart_wdata  = bus_wdata;

   // source for next-cycle read data
   always_comb begin
      src_d = SRC_ZERO;
      err_d = 1'b0;
      if (acc_rd) begin
         unique case (area)
            AREA_RAM:  src_d = SRC_RAM;
            AREA_VID:  begin
               if (vid_can_rd) src_d = SRC_VID;
               else            err_d = 1'b1;
            end
            AREA_CART: src_d = SRC_CART;
            default:   src_d = SRC_ZERO;
         endcase
      end
   end

   cbd_read_mux #(.DATA_W(DATA_W)) i_rmux (
      .clk   (clk),
      .rst_n (rst_n),
      .src_d (src_d),
      .err_d (err_d),
      .ram_q (ram_q),
      .vid_q (vid_rdata),
      .cart_q(cart_rdata),
      .rdata (bus_rdata),
      .err   (bus_err)
   );
endmodule

// File: rtl/cbd_bus_checker.sv
`timescale 1ns/1ps
module cbd_bus_checker #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int NUM_VID = 8,
   parameter logic [ADDR_W-1:0]  VID_BASE    = 'h2000,
   parameter logic [ADDR_W-1:0]  IO_BASE     = 'h4000,
   parameter logic [ADDR_W-1:0]  CART_BASE   = 'h4020,
   parameter logic [ADDR_W-1:0]  DMA_ADDR    = 'h4014,
   parameter logic [NUM_VID-1:0] VID_RD_MASK = 8'b1001_0100,
   localparam int VID_IW = $clog2(NUM_VID)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_err,
   input logic              vid_rd_stb,
   input logic              vid_wr_stb,
   input logic              dma_start,
   input logic [DATA_W-1:0] dma_page,
   input logic              cart_rd_stb,
   input logic              cart_wr_stb,
   input logic [DATA_W-1:0] cart_rdata
);
   logic [4:0] stbs;
   logic       vid_area, io_area, bad_vid_rd;

   assign stbs       = {vid_rd_stb, vid_wr_stb, dma_start, cart_rd_stb, cart_wr_stb};
   assign vid_area   = (bus_addr >= VID_BASE) && (bus_addr < IO_BASE);
   assign io_area    = (bus_addr >= IO_BASE) && (bus_addr < CART_BASE);
   assign bad_vid_rd = bus_valid && !bus_we && vid_area &&
                       !VID_RD_MASK[bus_addr[VID_IW-1:0]];

   assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stbs));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |-> (stbs == '0));

   assert_bad_read_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bad_vid_rd |=> (bus_err && bus_rdata == '0));

   assert_vid_read_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vid_rd_stb |-> (!bus_we && vid_area));

   assert_dma_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start |-> (bus_we && bus_addr == DMA_ADDR && dma_page == bus_wdata));

   assert_io_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_we && io_area) |=> (bus_rdata == '0 && !bus_err));

   assert_cart_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cart_rd_stb |=> (bus_rdata == cart_rdata));
endmodule

bind cbd_bus_decoder cbd_bus_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VID(NUM_VID),
   .VID_BASE(VID_BASE), .IO_BASE(IO_BASE), .CART_BASE(CART_BASE),
   .DMA_ADDR(DMA_ADDR), .VID_RD_MASK(VID_RD_MASK)
) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .bus_err(bus_err), .vid_rd_stb(vid_rd_stb), .vid_wr_stb(vid_wr_stb),
   .dma_start(dma_start), .dma_page(dma_page), .cart_rd_stb(cart_rd_stb),
   .cart_wr_stb(cart_wr_stb), .cart_rdata(cart_rdata)
);

// File: tb/test_cbd_bus_decoder.sv
`timescale 1ns/1ps
module test_cbd_bus_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        bus_err;
   logic        vid_rd_stb, vid_wr_stb;
   logic [2:0]  vid_idx;
   logic [7:0]  vid_wdata;
   logic [7:0]  vid_rdata = '0;
   logic        dma_start;
   logic [7:0]  dma_page;
   logic        cart_rd_stb, cart_wr_stb;
   logic [15:0] cart_addr;
   logic [7:0]  cart_wdata;
   logic [7:0]  cart_rdata = '0;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit rd_issue = 1'b0;
   bit done = 1'b0;

   logic [7:0] ref_ram [2048];
   logic [7:0] exp_data_q [$];
   bit         exp_err_q  [$];
   string      exp_req_q  [$];

   always #10 clk = ~clk;   // 50 MHz

   cbd_bus_decoder i_cbd_bus_decoder (.*);

   // device models owned by the bench
   function automatic logic [7:0] vid_val(input logic [2:0] i);
      return 8'hA0 | {5'd0, i};
   endfunction
   function automatic logic [7:0] cart_val(input logic [15:0] a);
      return a[15:8] ^ a[7:0] ^ 8'h5A;
   endfunction

   always @(posedge clk) begin
      if (vid_rd_stb)  vid_rdata  <= vid_val(vid_idx);
      if (cart_rd_stb) cart_rdata <= cart_val(cart_addr);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // monitor: pops one expected item for each read issued in the previous cycle
   always @(posedge clk) begin
      if (rd_issue) begin
         #2;
         if (exp_data_q.size() == 0) chk(1'b0, "scoreboard underflow", 0, 1);
         else begin
            logic [7:0] ed;
            bit ee;
            string rq;
            ed = exp_data_q.pop_front();
            ee = exp_err_q.pop_front();
            rq = exp_req_q.pop_front();
            chk(bus_rdata == ed, rq, bus_rdata, ed);
            chk(bus_err == ee, {rq, " err"}, bus_err, ee);
         end
      end
   end

   // driver: one access per cycle
   task automatic access(input bit we, input logic [15:0] a, input logic [7:0] d,
                         input logic [7:0] exp, input bit experr, input string req);
      @(negedge clk);
      bus_valid = 1'b1;
      bus_we    = we;
      bus_addr  = a;
      bus_wdata = d;
      rd_issue  = !we;
      if (!we) begin
         exp_data_q.push_back(exp);
         exp_err_q.push_back(experr);
         exp_req_q.push_back(req);
      end
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      bus_valid = 1'b0;
      rd_issue  = 1'b0;
      #1;
   endtask

   task automatic ram_wr(input logic [15:0] a, input logic [7:0] d);
      access(1'b1, a, d, 8'h00, 1'b0, "R1");
      ref_ram[a[10:0]] = d;
   endtask

   task automatic ram_rd(input logic [15:0] a);
      access(1'b0, a, 8'h00, ref_ram[a[10:0]], 1'b0, "R1 ram read");
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) ref_ram[i] = 8'h00;
      repeat (3) @(negedge clk);
      chk(bus_rdata == 8'h00, "R9 rdata", bus_rdata, 0);
      chk(bus_err == 1'b0, "R9 err", bus_err, 0);
      rst_n = 1'b1;

      // R1: mirrors
      ram_wr(16'h0005, 8'h11);
      ram_rd(16'h0805); ram_rd(16'h1005); ram_rd(16'h1805); ram_rd(16'h0005);
      ram_wr(16'h1FFF, 8'h22);
      ram_rd(16'h07FF); ram_rd(16'h0FFF);
      for (int i = 0; i < 24; i++) begin
         logic [15:0] wa;
         wa = 16'((i * 16'h0347 + 16'h0123) & 16'h1FFF);
         ram_wr(wa, 8'(i * 37 + 5));
      end
      for (int i = 0; i < 24; i++) begin
         logic [15:0] ra;
         ra = 16'(((i * 16'h0347 + 16'h0123) & 16'h07FF) | (16'(i % 4) << 11));
         ram_rd(ra);
      end

      // R2: writes to every index in the bottom and top copies
      for (int i = 0; i < 8; i++) begin
         access(1'b1, 16'h2000 + 16'(i), 8'(8'h30 + i), 8'h00, 1'b0, "R2");
         chk(vid_wr_stb == 1'b1, "R2 wr stb", vid_wr_stb, 1);
         chk(vid_idx == 3'(i), "R2 idx", vid_idx, i);
         chk(vid_wdata == 8'(8'h30 + i), "R2 wdata", vid_wdata, 8'h30 + i);
         access(1'b1, 16'h3FF8 + 16'(i), 8'h5C, 8'h00, 1'b0, "R2");
         chk(vid_wr_stb && vid_idx == 3'(i), "R2 top mirror", vid_idx, i);
      end

      // R3/R4: reads of every index, through varied mirrors
      for (int i = 0; i < 8; i++) begin
         logic [15:0] va;
         bit ok;
         va = 16'h2000 + 16'(i * 8 * 37) + 16'(i);
         ok = (i == 2 || i == 4 || i == 7);
         access(1'b0, va, 8'h00, ok ? vid_val(3'(i)) : 8'h00, !ok, ok ? "R3 vid read" : "R4 bad read");
         chk(vid_rd_stb == ok, ok ? "R3 rd stb" : "R4 no rd stb", vid_rd_stb, ok);
      end
      access(1'b0, 16'h3FFF, 8'h00, vid_val(3'd7), 1'b0, "R3 vid read edge");
      access(1'b0, 16'h2001, 8'h00, 8'h00, 1'b1, "R4 bad read b2b");
      access(1'b0, 16'h2005, 8'h00, 8'h00, 1'b1, "R4 bad read b2b");

      // R5: DMA trigger
      access(1'b1, 16'h4014, 8'h37, 8'h00, 1'b0, "R5");
      chk(dma_start == 1'b1, "R5 dma pulse", dma_start, 1);
      chk(dma_page == 8'h37, "R5 page", dma_page, 8'h37);
      access(1'b0, 16'h4014, 8'h00, 8'h00, 1'b0, "R5 read of dma addr");
      chk(dma_start == 1'b0, "R5 no dma on read", dma_start, 0);

      // R6: I/O window
      access(1'b1, 16'h4000, 8'hFF, 8'h00, 1'b0, "R6");
      chk({vid_rd_stb, vid_wr_stb, dma_start, cart_rd_stb, cart_wr_stb} == 5'b0, "R6 no strobe 4000", 0, 0);
      access(1'b1, 16'h401F, 8'hFF, 8'h00, 1'b0, "R6");
      chk({vid_rd_stb, vid_wr_stb, dma_start, cart_rd_stb, cart_wr_stb} == 5'b0, "R6 no strobe 401F", 0, 0);
      access(1'b1, 16'h4015, 8'h14, 8'h00, 1'b0, "R6");
      chk(dma_start == 1'b0, "R6 near dma", dma_start, 0);
      access(1'b0, 16'h4000, 8'h00, 8'h00, 1'b0, "R6 io read 4000");
      access(1'b0, 16'h401F, 8'h00, 8'h00, 1'b0, "R6 io read 401F");

      // R7: cartridge
      access(1'b1, 16'h4020, 8'h9D, 8'h00, 1'b0, "R7");
      chk(cart_wr_stb && cart_addr == 16'h4020 && cart_wdata == 8'h9D, "R7 cart write", cart_addr, 16'h4020);
      access(1'b0, 16'h4020, 8'h00, cart_val(16'h4020), 1'b0, "R7 cart read 4020");
      chk(cart_rd_stb == 1'b1, "R7 rd stb", cart_rd_stb, 1);
      access(1'b0, 16'hFFFF, 8'h00, cart_val(16'hFFFF), 1'b0, "R7 cart read FFFF");
      access(1'b0, 16'h8123, 8'h00, cart_val(16'h8123), 1'b0, "R7 cart read 8123");
      ram_rd(16'h0805);
      access(1'b0, 16'h2002, 8'h00, vid_val(3'd2), 1'b0, "R3 after ram");
      access(1'b0, 16'hC000, 8'h00, cart_val(16'hC000), 1'b0, "R7 after vid");

      // R8: nothing while bus_valid is low
      @(negedge clk);
      bus_valid = 1'b0; rd_issue = 1'b0;
      bus_we = 1'b1; bus_addr = 16'h4014; #1;
      chk({vid_rd_stb, vid_wr_stb, dma_start, cart_rd_stb, cart_wr_stb} == 5'b0, "R8 idle write", 0, 0);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 16'h2002; #1;
      chk({vid_rd_stb, vid_wr_stb, dma_start, cart_rd_stb, cart_wr_stb} == 5'b0, "R8 idle read", 0, 0);
      chk(bus_rdata == 8'h00, "R8 idle rdata", bus_rdata, 0);
      bus_addr = 16'h9000; #1;
      chk(cart_rd_stb == 1'b0, "R8 idle cart", cart_rd_stb, 0);
      idle(); idle();
      chk(exp_data_q.size() == 0, "scoreboard drained", exp_data_q.size(), 0);
      done = 1'b1;
   end

   // watchdog and summary
   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         done = 1'b1;
      end
   end

   initial begin
      wait (done);
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule